// File: doc/BRIEF.md
# FP32 Operand and Result Modifier Stage

This block sits on both sides of a single-precision arithmetic unit. On the way in, it rewrites the sign of each of three 32-bit operands. Each operand has its own magnitude-select bit and its own sign-flip bit, and the rewrite is purely combinational. On the way out, it takes the unit's result word and can scale it by a power of two. The scaling adjusts the exponent field only. The scaled value can then be saturated into the closed interval from zero to one. The finished word is registered and presented one cycle later with a valid strobe.

The arithmetic itself is outside the block. The caller drives the three operands and the two 3-bit modifier masks. It receives the modified operands in the same cycle. When the arithmetic unit produces a result, the caller pulses the result-valid input together with the scale code and the saturate bit.

Top module: `fp_mod_unit`

## Requirements
- R1: For each operand, when its magnitude bit is set and its flip bit is clear, the output sign is 0. When the flip bit alone is set, the sign is inverted. When both are set, the sign is 1 (minus the magnitude). Bits 30:0 always pass unchanged, including NaN payloads.
- R2: Mask bit 0 controls operand A, bit 1 controls operand B and bit 2 controls operand C. A bit for one operand never changes another operand.
- R3: The scale code selects the operation on a normal result as follows: 0 passes the word unchanged, 1 adds one to the exponent (×2), 2 adds two (×4), and 3 subtracts one (÷2).
- R4: If scaling pushes the exponent to 255 or above, the output is infinity (exponent 255, mantissa 0) with the input's sign.
- R5: Under a non-zero scale code, a result whose exponent would fall to 0 or below becomes a zero of the input's sign. A zero or denormal input also becomes a zero of the input's sign.
- R6: Infinity and NaN inputs pass through scaling unchanged.
- R7: With saturate set, any result with sign 1 (including -0 and -inf) becomes +0.0. Any positive value of 1.0 (0x3F800000) or more, including +inf, becomes exactly 0x3F800000. Other values are unchanged.
- R8: With saturate set, a NaN result becomes +0.0.
- R9: Scaling is applied before saturation.
- R10: The result-valid output follows the result-valid input by one clock. The result output updates only on a valid input and holds otherwise. After reset, both are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_a | input | 32 | Operand A |
| src_b | input | 32 | Operand B |
| src_c | input | 32 | Operand C |
| abs_mask | input | 3 | Per-operand magnitude select |
| neg_mask | input | 3 | Per-operand sign flip |
| op_a | output | 32 | Modified operand A |
| op_b | output | 32 | Modified operand B |
| op_c | output | 32 | Modified operand C |
| res_vld_in | input | 1 | Result word valid |
| res_in | input | 32 | Raw result word |
| omod | input | 2 | Scale code |
| clamp_en | input | 1 | Saturate to [0,1] |
| res_vld_out | output | 1 | Final result valid |
| res_out | output | 32 | Final result word |

## Verification
Exponent scaling and saturation can both act on the same result in the same cycle. The ordering between them decides the outcome. The bench sweeps every scale code with saturation both on and off across a set of special and ordinary words. It also includes values that only cross 1.0 after scaling, such as 0.375 × 4. A scale-after-clamp ordering would yield 1.5 there instead of 1.0. Operand sign rewriting is driven in the same cycles as result captures, to show that the two paths do not interfere.

// File: rtl/fp_mod_unit.sv
module fp_mod_unit #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [EXP_W+MAN_W:0]   src_a,
  input  logic [EXP_W+MAN_W:0]   src_b,
  input  logic [EXP_W+MAN_W:0]   src_c,
  input  logic [2:0]             abs_mask,
  input  logic [2:0]             neg_mask,
  output logic [EXP_W+MAN_W:0]   op_a,
  output logic [EXP_W+MAN_W:0]   op_b,
  output logic [EXP_W+MAN_W:0]   op_c,
  input  logic                   res_vld_in,
  input  logic [EXP_W+MAN_W:0]   res_in,
  input  logic [1:0]             omod,
  input  logic                   clamp_en,
  output logic                   res_vld_out,
  output logic [EXP_W+MAN_W:0]   res_out
);
  localparam int W = EXP_W + MAN_W + 1;
  localparam logic [EXP_W-1:0] EMAX = '1;
  localparam logic [EXP_W-1:0] BIAS = EMAX >> 1;
  localparam logic [W-1:0] ONE = {1'b0, BIAS, {MAN_W{1'b0}}};

  function automatic logic [W-1:0] sgn_mod(input logic [W-1:0] v, input logic a, input logic n);
    return {(a ? 1'b0 : v[W-1]) ^ n, v[W-2:0]};
  endfunction

  assign op_a = sgn_mod(src_a, abs_mask[0], neg_mask[0]);
  assign op_b = sgn_mod(src_b, abs_mask[1], neg_mask[1]);
  assign op_c = sgn_mod(src_c, abs_mask[2], neg_mask[2]);

  logic                    r_sgn;
  logic [EXP_W-1:0]        r_exp;
  logic signed [EXP_W+1:0] delta, e_new;
  logic [W-1:0]            scaled, final_w;

  assign r_sgn = res_in[W-1];
  assign r_exp = res_in[W-2:MAN_W];

  always_comb begin
    case (omod)
      2'd1:    delta = 1;
      2'd2:    delta = 2;
      2'd3:    delta = -1;
      default: delta = 0;
    endcase
    e_new = $signed({2'b00, r_exp}) + delta;
    if (omod == 2'd0 || r_exp == EMAX)
      scaled = res_in;
    else if (r_exp == '0 || e_new <= 0)
      scaled = {r_sgn, {(W-1){1'b0}}};
    else if (e_new >= $signed({2'b00, EMAX}))
      scaled = {r_sgn, EMAX, {MAN_W{1'b0}}};
    else
      scaled = {r_sgn, e_new[EXP_W-1:0], res_in[MAN_W-1:0]};
  end

  always_comb begin
    if (!clamp_en)
      final_w = scaled;
    else if (scaled[W-1] || (scaled[W-2:MAN_W] == EMAX && scaled[MAN_W-1:0] != '0))
      final_w = '0;
    else if (scaled[W-2:0] >= ONE[W-2:0])
      final_w = ONE;
    else
      final_w = scaled;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_vld_out <= 1'b0;
      res_out     <= '0;
    end else begin
      res_vld_out <= res_vld_in;
      if (res_vld_in) res_out <= final_w;
    end
  end
endmodule

module fp_mod_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] src_a,
  input logic [31:0] src_b,
  input logic [31:0] src_c,
  input logic [2:0]  abs_mask,
  input logic [2:0]  neg_mask,
  input logic [31:0] op_a,
  input logic [31:0] op_b,
  input logic [31:0] op_c,
  input logic        res_vld_in,
  input logic [31:0] res_in,
  input logic [1:0]  omod,
  input logic        clamp_en,
  input logic        res_vld_out,
  input logic [31:0] res_out
);
  p_mag_keep_r1: assert property (@(posedge clk) disable iff (!rst_n)
    op_a[30:0] == src_a[30:0] && op_b[30:0] == src_b[30:0] && op_c[30:0] == src_c[30:0]);
  p_both_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (abs_mask[1] && neg_mask[1]) |-> op_b[31]);
  p_untouched_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!abs_mask[2] && !neg_mask[2]) |-> op_c == src_c);
  p_vld_lat_r10: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld_in |=> res_vld_out);
  p_vld_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !res_vld_in |=> !res_vld_out);
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !res_vld_in |=> $stable(res_out));
  p_clamp_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld_in && clamp_en) |=> res_out <= 32'h3F80_0000);
  p_nan_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld_in && clamp_en && res_in[30:23] == 8'hFF && res_in[22:0] != 0) |=> res_out == 32'h0);
  p_special_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld_in && !clamp_en && res_in[30:23] == 8'hFF) |=> res_out == $past(res_in));
endmodule

bind fp_mod_unit fp_mod_unit_chk u_chk (.*);

// File: tb/fp_mod_unit_bench.sv
module fp_mod_unit_bench;
  localparam int PERIOD = 10;
  logic clk = 0, rst_n = 0;
  logic [31:0] src_a = 0, src_b = 0, src_c = 0, res_in = 0;
  logic [2:0] abs_mask = 0, neg_mask = 0;
  logic [1:0] omod = 0;
  logic clamp_en = 0, res_vld_in = 0;
  logic [31:0] op_a, op_b, op_c, res_out;
  logic res_vld_out;
  int checks = 0, failures = 0;

  always #(PERIOD/2) clk = ~clk;

  fp_mod_unit u_fp_mod_unit (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_src(input logic [31:0] v, input bit a, input bit n);
    bit s;
    s = v[31];
    if (a) s = 0;
    if (n) s = ~s;
    return {s, v[30:0]};
  endfunction

  function automatic logic [31:0] exp_res(input logic [31:0] v, input int om, input bit cl);
    int e, k;
    logic [31:0] r;
    bit nan;
    e = int'(v[30:23]);
    k = (om == 1) ? 1 : (om == 2) ? 2 : (om == 3) ? -1 : 0;
    if (k == 0 || e == 255) r = v;
    else if (e == 0 || e + k < 1) r = {v[31], 31'd0};
    else if (e + k > 254) r = {v[31], 8'hFF, 23'd0};
    else r = {v[31], 8'(e + k), v[22:0]};
    if (!cl) return r;
    nan = (r[30:23] == 8'hFF) && (r[22:0] != 0);
    if (nan || r[31]) return 32'h0;
    if (r[30:0] >= 31'h3F80_0000) return 32'h3F80_0000;
    return r;
  endfunction

  task automatic push(input logic [31:0] v, input int om, input bit cl);
    @(negedge clk);
    res_in = v; omod = 2'(om); clamp_en = cl; res_vld_in = 1;
    @(negedge clk);
    res_vld_in = 0;
  endtask

  logic [31:0] vals [14] = '{32'h3FC0_0000, 32'hBF40_0000, 32'h3E80_0000, 32'h7F7F_FFFF,
                             32'h0080_0000, 32'h0000_0000, 32'h8000_0000, 32'h0000_1234,
                             32'h7F80_0000, 32'hFF80_0000, 32'h7FC0_0001, 32'h3F80_0000,
                             32'h3EC0_0000, 32'hFFC0_0005};

  initial begin
    #(PERIOD * 100000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 reset vld", {31'd0, res_vld_out}, 32'd0);
    chk("R10 reset data", res_out, 32'd0);
    rst_n = 1;

    // R1 R2: all mask combinations over several operand words
    for (int p = 0; p < 4; p++) begin
      for (int m = 0; m < 64; m++) begin
        @(negedge clk);
        src_a = vals[p*3]; src_b = vals[p*3+1]; src_c = vals[p*3+2] ^ 32'h8000_0000;
        abs_mask = m[2:0]; neg_mask = m[5:3];
        #1;
        chk("R1/R2 op_a", op_a, exp_src(src_a, m[0], m[3]));
        chk("R1/R2 op_b", op_b, exp_src(src_b, m[1], m[4]));
        chk("R1/R2 op_c", op_c, exp_src(src_c, m[2], m[5]));
      end
    end
    @(negedge clk);
    src_a = 32'h7FC0_0001; abs_mask = 3'b001; neg_mask = 3'b001; #1;
    chk("R1 nan payload abs+neg", op_a, 32'hFFC0_0001);

    // R3..R9 sweep; operand path kept busy in the same cycles
    for (int om = 0; om < 4; om++)
      for (int cl = 0; cl < 2; cl++)
        for (int i = 0; i < 14; i++) begin
          src_b = vals[i]; abs_mask = 3'b010; neg_mask = 3'b000;
          push(vals[i], om, cl[0]);
          chk("R10 vld", {31'd0, res_vld_out}, 32'd1);
          chk("R3-9 sweep", res_out, exp_res(vals[i], om, cl[0]));
          chk("R2 concurrent op_b", op_b, {1'b0, vals[i][30:0]});
          @(negedge clk);
          chk("R10 hold", res_out, exp_res(vals[i], om, cl[0]));
          chk("R10 idle vld", {31'd0, res_vld_out}, 32'd0);
        end

    push(32'h3FC0_0000, 1, 0); chk("R3 1.5*2", res_out, 32'h4040_0000);
    push(32'h3FC0_0000, 2, 0); chk("R3 1.5*4", res_out, 32'h40C0_0000);
    push(32'hBF40_0000, 3, 0); chk("R3 -0.75/2", res_out, 32'hBEC0_0000);
    push(32'hFF7F_FFFF, 1, 0); chk("R4 -max*2", res_out, 32'hFF80_0000);
    push(32'h7F00_0000, 2, 0); chk("R4 big*4", res_out, 32'h7F80_0000);
    push(32'h8080_0000, 3, 0); chk("R5 -min/2", res_out, 32'h8000_0000);
    push(32'h8000_0042, 1, 0); chk("R5 denorm*2", res_out, 32'h8000_0000);
    push(32'hFFC0_0005, 2, 0); chk("R6 nan*4", res_out, 32'hFFC0_0005);
    push(32'h3F40_0000, 0, 1); chk("R7 0.75 in range", res_out, 32'h3F40_0000);
    push(32'h8000_0000, 0, 1); chk("R7 -0 clamp", res_out, 32'h0);
    push(32'h7F80_0000, 0, 1); chk("R7 +inf clamp", res_out, 32'h3F80_0000);
    push(32'h7FC0_0000, 0, 1); chk("R8 nan clamp", res_out, 32'h0);
    push(32'h3EC0_0000, 2, 1); chk("R9 0.375*4 clamp", res_out, 32'h3F80_0000);
    push(32'h3F40_0000, 3, 1); chk("R9 0.75/2 clamp", res_out, 32'h3EC0_0000);

    @(negedge clk);
    res_in = 32'h1234_5678; omod = 1; clamp_en = 0; res_vld_in = 0;
    @(negedge clk);
    chk("R10 no capture", res_out, 32'h3EC0_0000);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule